// File: doc/BRIEF.md
# Predicate Bank with Zero-Test Compares

This block keeps the one-bit predicates of a two-operation VLIW core and turns them into per-operation execute enables. Each operation slot may carry a compare that tests a signed operand against zero and writes the outcome into a chosen predicate bit. Each slot also names a predicate bit and carries a flag that says whether its operation is conditional on that bit.

The enables are combinational from the stored bits and the slot's index, so the gated datapath sees them in the same cycle. A compare writes at the clock edge that ends its instruction, so the instruction that follows already sees the new value. The instruction issuing the compare still sees the old value. If both slots write the same bit in one cycle, slot 1 wins.

Top module: `pred_unit`

## Requirements
- R1: After reset, all 32 predicate bits (indices 0..31) read as 0.
- R2: Compare code 0 (less than zero) writes 1 to the target bit when the 32-bit operand is negative (bit 31 set), and 0 otherwise.
- R3: Compare code 1 (at least zero) writes 1 when the operand is zero or positive, and 0 when it is negative.
- R4: Compare code 2 (is zero) writes 1 when the operand equals 0, and 0 otherwise.
- R5: Compare code 3 (non-zero) writes 1 when the operand differs from 0, and 0 otherwise.
- R6: A slot whose predicated flag is 1 has its enable equal to the predicate bit chosen by that slot's own 5-bit index. The two slots choose their bits independently.
- R7: A slot whose predicated flag is 0 has its enable at 1, whatever the predicate contents.
- R8: A compare changes the enables of the next instruction, one cycle later. The enables of the instruction carrying the compare still reflect the old bit.
- R9: When both slots issue valid compares to the same bit in one cycle, the bit takes slot 1's outcome.
- R10: A compare changes only its target bit. All other bits keep their values.
- R11: A compare whose valid bit is 0 changes no predicate bit, whatever its code, target or operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_vld_i | input | 2 | Per-slot compare valid, bit s for slot s |
| cmp_op_i | input | 4 | Per-slot compare code, slot s in bits [2s+1:2s] |
| cmp_dst_i | input | 10 | Per-slot target bit index, slot s in bits [5s+4:5s] |
| cmp_opnd_i | input | 64 | Per-slot signed operand, slot s in bits [32s+31:32s] |
| slot_pred_i | input | 2 | Per-slot predicated flag |
| slot_idx_i | input | 10 | Per-slot predicate index, slot s in bits [5s+4:5s] |
| slot_en_o | output | 2 | Per-slot execute enable |

## Verification
The case hardest to reach from the ports is the one where a compare and a read of the same bit meet. This happens either within one instruction, where the old value must be seen, or across two consecutive instructions, where the new value must be seen. A dual write to one bit is equally hard to reach. Directed instructions put each compare, and a slot that reads its target, into the same cycle and into the next one. Both slots are aimed at a shared bit with opposing outcomes, in both orders. A long pseudo-random run then mixes dual compares, colliding targets and predicated reads. Full sweeps of all 32 bits confirm that nothing outside the target moved.

// File: rtl/pred_pkg.sv
package pred_pkg;
  typedef enum logic [1:0] {
    CMP_LTZ = 2'd0,
    CMP_GEZ = 2'd1,
    CMP_EQZ = 2'd2,
    CMP_NEZ = 2'd3
  } cmp_op_e;
endpackage

// File: rtl/pred_cmp_eval.sv
module pred_cmp_eval
  import pred_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cmp_op_e           op_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic              hit_o
);
  logic is_neg;
  logic is_zero;

  assign is_neg  = opnd_i[DATA_W-1];
  assign is_zero = (opnd_i == '0);

  always_comb begin
    unique case (op_i)
      CMP_LTZ: hit_o = is_neg;
      CMP_GEZ: hit_o = ~is_neg;
      CMP_EQZ: hit_o = is_zero;
      CMP_NEZ: hit_o = ~is_zero;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int NUM_PRED  = 32,
  parameter int NUM_SLOTS = 2,
  parameter int IDX_W     = $clog2(NUM_PRED)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SLOTS-1:0]       wr_en_i,
  input  logic [NUM_SLOTS*IDX_W-1:0] wr_idx_i,
  input  logic [NUM_SLOTS-1:0]       wr_val_i,
  output logic [NUM_PRED-1:0]        pred_o
);
  logic [NUM_PRED-1:0] pred_q, pred_d;

  // higher slot applied last, so it wins a shared target
  always_comb begin
    pred_d = pred_q;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (wr_en_i[s]) pred_d[wr_idx_i[s*IDX_W +: IDX_W]] = wr_val_i[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pred_q <= '0;
    else         pred_q <= pred_d;
  end

  assign pred_o = pred_q;

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i == '0) |=> $stable(pred_q));

  generate
    if (NUM_SLOTS > 1) begin : g_prio
      logic [IDX_W-1:0] idx0, idx1;
      assign idx0 = wr_idx_i[0 +: IDX_W];
      assign idx1 = wr_idx_i[IDX_W +: IDX_W];
      p_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i[0] && wr_en_i[1] && idx0 == idx1)
        |=> pred_q[$past(idx1)] == $past(wr_val_i[1]));
    end
  endgenerate
endmodule

// File: rtl/pred_sel.sv
module pred_sel #(
  parameter int NUM_PRED = 32,
  parameter int IDX_W    = $clog2(NUM_PRED)
) (
  input  logic [NUM_PRED-1:0] pred_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                guarded_i,
  output logic                en_o
);
  assign en_o = ~guarded_i | pred_i[idx_i];
endmodule

// File: rtl/pred_unit.sv
module pred_unit
  import pred_pkg::*;
#(
  parameter int NUM_PRED  = 32,
  parameter int NUM_SLOTS = 2,
  parameter int DATA_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SLOTS-1:0]        cmp_vld_i,
  input  logic [NUM_SLOTS*2-1:0]      cmp_op_i,
  input  logic [NUM_SLOTS*$clog2(NUM_PRED)-1:0] cmp_dst_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] cmp_opnd_i,
  input  logic [NUM_SLOTS-1:0]        slot_pred_i,
  input  logic [NUM_SLOTS*$clog2(NUM_PRED)-1:0] slot_idx_i,
  output logic [NUM_SLOTS-1:0]        slot_en_o
);
  localparam int IDX_W = $clog2(NUM_PRED);
  localparam int OP_W  = 2;

  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_PRED-1:0]  pred_q;

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      pred_cmp_eval #(.DATA_W(DATA_W)) u_eval (
        .op_i   (cmp_op_e'(cmp_op_i[s*OP_W +: OP_W])),
        .opnd_i (cmp_opnd_i[s*DATA_W +: DATA_W]),
        .hit_o  (hit[s])
      );

      pred_sel #(.NUM_PRED(NUM_PRED), .IDX_W(IDX_W)) u_sel (
        .pred_i    (pred_q),
        .idx_i     (slot_idx_i[s*IDX_W +: IDX_W]),
        .guarded_i (slot_pred_i[s]),
        .en_o      (slot_en_o[s])
      );

      p_unpred_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !slot_pred_i[s] |-> slot_en_o[s]);
    end
  endgenerate

  pred_bank #(.NUM_PRED(NUM_PRED), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (cmp_vld_i),
    .wr_idx_i (cmp_dst_i),
    .wr_val_i (hit),
    .pred_o   (pred_q)
  );

  generate
    if (NUM_SLOTS > 1) begin : g_chk
      logic [IDX_W-1:0]  dst0, dst1, ix0;
      logic [OP_W-1:0]   op0, op1;
      logic [DATA_W-1:0] v0, v1;
      assign dst0 = cmp_dst_i[0 +: IDX_W];
      assign dst1 = cmp_dst_i[IDX_W +: IDX_W];
      assign ix0  = slot_idx_i[0 +: IDX_W];
      assign op0  = cmp_op_i[0 +: OP_W];
      assign op1  = cmp_op_i[OP_W +: OP_W];
      assign v0   = cmp_opnd_i[0 +: DATA_W];
      assign v1   = cmp_opnd_i[DATA_W +: DATA_W];

      p_ltz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_vld_i[0] && op0 == OP_W'(CMP_LTZ) && !(cmp_vld_i[1] && dst1 == dst0))
        |=> pred_q[$past(dst0)] == $past(v0[DATA_W-1]));

      p_eqz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_vld_i[1] && op1 == OP_W'(CMP_EQZ))
        |=> pred_q[$past(dst1)] == ($past(v1) == '0));

      p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_vld_i[1]
        |=> (!(slot_pred_i[0] && ix0 == $past(dst1)) || slot_en_o[0] == $past(hit[1])));
    end
  endgenerate
endmodule

// File: tb/tb_pred_unit.sv
module tb_pred_unit;
  localparam int CLK_P = 10;

  typedef struct {
    int    slot;
    logic  exp;
    string tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cmp_vld_i = '0;
  logic [3:0]  cmp_op_i = '0;
  logic [9:0]  cmp_dst_i = '0;
  logic [63:0] cmp_opnd_i = '0;
  logic [1:0]  slot_pred_i = '0;
  logic [9:0]  slot_idx_i = '0;
  logic [1:0]  slot_en_o;

  item_t       sb_q[$];
  logic [31:0] m_pred = '0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_P/2) clk_i = ~clk_i;

  pred_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_vld_i(cmp_vld_i), .cmp_op_i(cmp_op_i),
    .cmp_dst_i(cmp_dst_i), .cmp_opnd_i(cmp_opnd_i), .slot_pred_i(slot_pred_i),
    .slot_idx_i(slot_idx_i), .slot_en_o(slot_en_o)
  );

  function automatic logic cmp_hit(input logic [1:0] op, input logic [31:0] v);
    case (op)
      2'd0: return v[31];
      2'd1: return ~v[31];
      2'd2: return v == 0;
      default: return v != 0;
    endcase
  endfunction

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // driver: apply one instruction, push expected enables, advance model
  task automatic issue(input logic [1:0] vld,
                       input logic [1:0] op0, input int dst0, input logic [31:0] v0,
                       input logic [1:0] op1, input int dst1, input logic [31:0] v1,
                       input logic [1:0] prd, input int ix0, input int ix1,
                       input string tag);
    item_t it;
    @(negedge clk_i);
    cmp_vld_i   = vld;
    cmp_op_i    = {op1, op0};
    cmp_dst_i   = {5'(dst1), 5'(dst0)};
    cmp_opnd_i  = {v1, v0};
    slot_pred_i = prd;
    slot_idx_i  = {5'(ix1), 5'(ix0)};
    it.tag = tag;
    it.slot = 0; it.exp = ~prd[0] | m_pred[ix0]; sb_q.push_back(it);
    it.slot = 1; it.exp = ~prd[1] | m_pred[ix1]; sb_q.push_back(it);
    if (vld[0]) m_pred[dst0] = cmp_hit(op0, v0);
    if (vld[1]) m_pred[dst1] = cmp_hit(op1, v1);
  endtask

  task automatic probe(input int ix0, input int ix1, input string tag);
    issue(2'b00, 2'd0, 0, 32'hFFFF_FFFF, 2'd1, 0, 0, 2'b11, ix0, ix1, tag);
  endtask

  task automatic cmp0(input logic [1:0] op, input int dst, input logic [31:0] v,
                      input string tag);
    issue(2'b01, op, dst, v, 2'd0, 0, 0, 2'b11, dst, dst, tag);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 32; i += 2) probe(i, i + 1, tag);
  endtask

  // monitor: pop and compare away from the clock edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk_i);
      #(CLK_P/4);
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_chk++;
        if (slot_en_o[it.slot] !== it.exp) begin
          n_bad++;
          $display("FAIL %s slot%0d: en=%0b exp=%0b", it.tag, it.slot,
                   slot_en_o[it.slot], it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: en=x exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    sweep("R1");                                              // all zero after reset
    issue(2'b00, 0, 0, 0, 0, 0, 0, 2'b00, 3, 4, "R7");         // unpredicated -> on

    cmp0(2'd0, 5, 32'hFFFF_FFF9, "R8");  probe(5, 5, "R2");    // -7 -> 1
    cmp0(2'd0, 5, 32'h0, "R8");          probe(5, 5, "R2");    // 0 -> 0
    cmp0(2'd0, 5, 32'h8000_0000, "R8");  probe(5, 5, "R2");
    cmp0(2'd0, 5, 32'h7FFF_FFFF, "R8");  probe(5, 5, "R2");

    cmp0(2'd1, 6, 32'h0, "R8");          probe(6, 6, "R3");
    cmp0(2'd1, 6, 32'hFFFF_FFFF, "R8");  probe(6, 6, "R3");
    cmp0(2'd1, 6, 32'd100, "R8");        probe(6, 6, "R3");

    cmp0(2'd2, 7, 32'h0, "R8");          probe(7, 7, "R4");
    cmp0(2'd2, 7, 32'h1, "R8");          probe(7, 7, "R4");
    cmp0(2'd2, 0, 32'h0, "R8");          probe(0, 0, "R4");

    cmp0(2'd3, 31, 32'h0, "R8");         probe(31, 31, "R5");
    cmp0(2'd3, 31, 32'hFFFF_FFFF, "R8"); probe(31, 31, "R5");

    issue(2'b00, 0, 0, 0, 0, 0, 0, 2'b01, 31, 7, "R7");        // slot1 unpredicated
    issue(2'b00, 0, 0, 0, 0, 0, 0, 2'b11, 31, 7, "R6");        // independent indices

    // dual write to one bit, both orders
    issue(2'b11, 2'd2, 9, 32'h0, 2'd2, 9, 32'd5, 2'b11, 9, 9, "R9");
    probe(9, 9, "R9");
    issue(2'b11, 2'd3, 9, 32'h0, 2'd3, 9, 32'd5, 2'b11, 9, 9, "R9");
    probe(9, 9, "R9");

    sweep("R10");

    // invalid compares that would flip bits
    issue(2'b00, 2'd2, 5, 32'h0, 2'd3, 31, 32'h0, 2'b11, 5, 31, "R11");
    probe(5, 31, "R11");
    sweep("R11");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = rnd();
      logic [31:0] a = rnd();
      logic [31:0] b = rnd();
      issue(r[1:0], r[3:2], int'(r[8:4]), (r[9] ? 32'h0 : a),
            r[11:10], int'(r[16:12]), (r[17] ? 32'h0 : b),
            r[19:18], int'(r[24:20]), int'(r[29:25]), "R6");
    end
    sweep("R10");

    @(negedge clk_i);
    @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule